// File: doc/BRIEF.md
# Watchdog Timer with Selectable Reset or NMI Action

This block is a watchdog counter for a small microcontroller. Software configures it through a control register on a simple read/write bus. Once software enables it, the enable stays set until a reset. From then on, software must restart the counter in time by writing a two-byte key to a separate restart register.

If the counter reaches the end of its period, the block sets a timeout flag. It then raises a one-cycle pulse on one of two outputs. By default this is a system reset request. If the action-select bit was set before enabling, it is a non-maskable interrupt instead. The flag survives the system reset that the watchdog itself provokes, so the start-up code can read it to learn why the chip restarted.

The counter advances on every clock cycle, or only on cycles where an already synchronised slow tick (from a 32.768 kHz source) is high. The parameter `SHIFT` divides every period by 2^SHIFT so that short runs stay practical. The bus, the tick and both outputs are plain signals with no handshake. A write takes effect on the clock edge where `bus_sel` and `bus_wr` are high, and a read returns data in the same cycle.

Top module: `wdog_top`

## Requirements
- R1: After a power-on reset (`por_n` low), the control register reads 0x00. Both outputs stay low, and the counter does not run for as long as bit 7 of the control register is 0.
- R2: A write to the control register (address 0) with bit 7 set enables the watchdog. Without a restart, the first timeout fires on the P-th counting edge after that write edge.
- R3: Once enabled, the watchdog cannot be disabled by a control write with bit 7 clear. Bit 7 reads 1 and timeouts continue.
- R4: Control bits [1:0] pick the period P in counts: 00 gives 2^(18-SHIFT), 01 gives 2^(22-SHIFT), 10 gives 2^(25-SHIFT), and 11 gives 2^(27-SHIFT).
- R5: While the watchdog is enabled, control writes leave bits [3:0] unchanged. Those bits are bit 3 (slow-tick source), bit 2 (NMI select) and bits [1:0] (period). They can only be set by the write that enables the watchdog or by an earlier write.
- R6: A timeout sets bit 6 (timeout flag) of the control register. Writing 1 to bit 6 clears it. Writing 0 to bit 6 leaves it unchanged.
- R7: With bit 2 at 0, a timeout produces a one-cycle high pulse on `rst_req` in the cycle after the expiring edge, and `nmi_req` stays low.
- R8: With bit 2 at 1, a timeout produces a one-cycle high pulse on `nmi_req`, and `rst_req` stays low.
- R9: The counter clears when two consecutive writes to the restart register (address 1) carry the bytes 0xA5 and then 0x5A. The next timeout then falls P counting edges after the 0x5A write. A restart completing on the same edge as an expiry suppresses that timeout.
- R10: Any other byte sequence to the restart register does not clear the counter. This includes a lone 0x5A, and 0xA5 followed by another byte and then 0x5A.
- R11: With bit 3 at 1, the counter advances only on edges where `slow_tick` is high.
- R12: The timeout flag survives a system reset (`rst_n` low), which clears all other control bits. Only `por_n` clears it.
- R13: After a timeout the counter starts again from zero, so an unattended watchdog fires every P counting edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything including the flag |
| rst_n | input | 1 | System reset, active low, asynchronous; keeps the timeout flag |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address: 0 control, 1 restart |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational; the restart register reads 0 |
| slow_tick | input | 1 | Synchronised slow-source count enable |
| rst_req | output | 1 | One-cycle system reset request on timeout |
| nmi_req | output | 1 | One-cycle non-maskable interrupt on timeout |

## Verification
A write becomes visible in the control register, and can count as a restart, at the clock edge that samples it. Read data is combinational, so the bench reads in the low clock phase with no wait. A timeout pulse is registered: it appears in the cycle that follows the P-th counting edge after the enabling or restarting write. The bench numbers every rising edge, records the edge of each write, and expects the pulse at exactly write edge plus P. With the slow source, it expects the pulse at the edge of the P-th tick it issued. During the random restart phase, a cycle-by-cycle bench model predicts the pulse for every edge. The bench compares the model's prediction with the outputs one half cycle after each edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // period choices, value equals the control-register field encoding
  typedef enum logic [1:0] {
    PER_18 = 2'b00,
    PER_22 = 2'b01,
    PER_25 = 2'b10,
    PER_27 = 2'b11
  } per_sel_e;

  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned KICK_ADDR = 1;

  localparam logic [7:0] KEY_ARM  = 8'hA5;
  localparam logic [7:0] KEY_FIRE = 8'h5A;

  localparam int unsigned BIT_EN   = 7;
  localparam int unsigned BIT_FLAG = 6;
  localparam int unsigned BIT_SRC  = 3;
  localparam int unsigned BIT_NMI  = 2;

  localparam int unsigned MAX_EXP = 27;

  typedef struct packed {
    logic     en;
    logic     nmi_sel;
    logic     slow_src;
    per_sel_e per;
  } cfg_t;

  // log2 of the scaled period in counts
  function automatic int unsigned per_exp(per_sel_e s, int unsigned shift);
    case (s)
      PER_18:  return 18 - shift;
      PER_22:  return 22 - shift;
      PER_25:  return 25 - shift;
      default: return 27 - shift;
    endcase
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              por_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              expire,
  output cfg_t              cfg,
  output logic              kick_stb,
  output logic [7:0]        rdata
);
  logic ctrl_wr;
  logic flag_q;
  cfg_t cfg_q;

  assign ctrl_wr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
  assign kick_stb = bus_sel && bus_wr && (bus_addr == ADDR_W'(KICK_ADDR));

  // configuration: writable only while disabled; enable is set-only
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      cfg_q <= '0;
    end else if (ctrl_wr && !cfg_q.en) begin
      cfg_q.en       <= bus_wdata[BIT_EN];
      cfg_q.nmi_sel  <= bus_wdata[BIT_NMI];
      cfg_q.slow_src <= bus_wdata[BIT_SRC];
      cfg_q.per      <= per_sel_e'(bus_wdata[1:0]);
    end
  end

  // timeout flag: kept across system reset, cleared by power-on or write-one
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flag_q <= 1'b0;
    end else if (expire) begin
      flag_q <= 1'b1;
    end else if (ctrl_wr && bus_wdata[BIT_FLAG]) begin
      flag_q <= 1'b0;
    end
  end

  assign cfg = cfg_q;

  always_comb begin
    rdata = '0;
    if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
      rdata[BIT_EN]   = cfg_q.en;
      rdata[BIT_FLAG] = flag_q;
      rdata[BIT_SRC]  = cfg_q.slow_src;
      rdata[BIT_NMI]  = cfg_q.nmi_sel;
      rdata[1:0]      = cfg_q.per;
    end
  end

  // R3
  en_sticky_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    cfg_q.en |=> cfg_q.en);

  // R5
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    cfg_q.en |=> $stable({cfg_q.nmi_sel, cfg_q.slow_src, cfg_q.per}));

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    expire |=> flag_q);
endmodule

// File: rtl/wdog_kick.sv
module wdog_kick
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [7:0] wdata,
  output logic       restart
);
  logic armed_q;

  assign restart = wr_stb && armed_q && (wdata == KEY_FIRE);

  // armed only directly after a write of the first key byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (wr_stb) begin
      armed_q <= (wdata == KEY_ARM);
    end
  end

  // R10
  lone_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wdata != KEY_ARM) |=> !restart);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int unsigned SHIFT = 12,
  parameter int unsigned CNT_W = MAX_EXP - SHIFT
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     slow_src,
  input  logic     slow_tick,
  input  per_sel_e per,
  input  logic     restart,
  output logic     expire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             adv;

  always_comb begin
    last = CNT_W'((64'd1 << per_exp(per, SHIFT)) - 64'd1);
  end

  assign adv    = en && (slow_src ? slow_tick : 1'b1);
  assign expire = adv && !restart && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || expire) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);

  // R9
  restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q));

  // R11
  slow_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && slow_src && !slow_tick && !restart) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_action.sv
module wdog_action (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic nmi_sel,
  output logic rst_req,
  output logic nmi_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      nmi_req <= 1'b0;
    end else begin
      rst_req <= expire && !nmi_sel;
      nmi_req <= expire && nmi_sel;
    end
  end

  // R8
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_req, nmi_req}));

  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned SHIFT  = 12
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              slow_tick,
  output logic              rst_req,
  output logic              nmi_req
);
  localparam int unsigned CNT_W = MAX_EXP - SHIFT;

  logic sys_rst_n;
  logic kick_stb;
  logic restart;
  logic expire;
  cfg_t cfg;

  assign sys_rst_n = por_n & rst_n;

  wdog_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .sys_rst_n(sys_rst_n), .por_n(por_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .expire(expire), .cfg(cfg),
    .kick_stb(kick_stb), .rdata(bus_rdata)
  );

  wdog_kick u_kick (
    .clk(clk), .rst_n(sys_rst_n), .wr_stb(kick_stb),
    .wdata(bus_wdata), .restart(restart)
  );

  wdog_counter #(.SHIFT(SHIFT), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(sys_rst_n), .en(cfg.en), .slow_src(cfg.slow_src),
    .slow_tick(slow_tick), .per(cfg.per), .restart(restart),
    .expire(expire)
  );

  wdog_action u_act (
    .clk(clk), .rst_n(sys_rst_n), .expire(expire),
    .nmi_sel(cfg.nmi_sel), .rst_req(rst_req), .nmi_req(nmi_req)
  );
endmodule

// File: tb/tb_wdog_top.sv
module tb_wdog_top;
  localparam int unsigned SHIFT = 14;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       slow_tick = 1'b0;
  logic       tick_en = 1'b0;
  logic       rst_req;
  logic       nmi_req;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  wdog_top #(.ADDR_W(2), .SHIFT(SHIFT)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .slow_tick(slow_tick), .rst_req(rst_req),
    .nmi_req(nmi_req)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  // ticks land on edges whose index is a multiple of 4
  always @(negedge clk) slow_tick <= tick_en && (((cyc + 1) % 4) == 0);

  function automatic int period(input int sel);
    case (sel)
      0: return 1 << (18 - SHIFT);
      1: return 1 << (22 - SHIFT);
      2: return 1 << (25 - SHIFT);
      default: return 1 << (27 - SHIFT);
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, output int edge_idx);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    edge_idx = cyc;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 v = bus_rdata;
    bus_sel = 0;
  endtask

  // waits for a pulse on the chosen output; flags any pulse on the other
  task automatic wait_pulse(input bit use_nmi, input int limit, input string req,
                            output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if ((use_nmi ? rst_req : nmi_req) == 1'b1)
        chk(req, 1, 0);
      if ((use_nmi ? nmi_req : rst_req) == 1'b1) begin
        at = cyc;
        break;
      end
    end
  endtask

  task automatic apply_reset(input bit power);
    rst_n = 0;
    if (power) por_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; por_n = 1;
    @(negedge clk);
  endtask

  initial begin : main
    int e, e2, v, at, p;
    int mcnt;
    bit armed, exp_p, w;
    logic [7:0] b;
    void'($urandom(32'd4242));

    apply_reset(1);
    // R1: reset state and no activity while disabled
    rd(2'd0, v); chk("R1 ctrl after power-on", v, 8'h00);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (rst_req || nmi_req) chk("R1 idle outputs", 1, 0);
    end
    chk("R1 outputs low", {rst_req, nmi_req}, 0);

    // R2 R4 R7: enable, period 00, reset action
    p = period(0);
    wr(2'd0, 8'h80, e);
    wait_pulse(0, 4 * p, "R8 nmi must stay low", at);
    chk("R2 R4 first timeout edge", at, e + p);
    @(negedge clk);
    chk("R7 pulse one cycle", rst_req, 0);
    rd(2'd0, v); chk("R6 flag set", v, 8'hC0);

    // R13: periodic refire
    wait_pulse(0, 4 * p, "R8 nmi must stay low", e2);
    chk("R13 refire after P", e2, at + p);

    // R3 R5: disable and reconfigure attempts ignored
    wr(2'd0, 8'h00, e);
    wr(2'd0, 8'h0F, e);
    rd(2'd0, v); chk("R3 R5 ctrl unchanged", v, 8'hC0);
    // R6: write-one clears flag, enable stays
    wr(2'd0, 8'h40, e);
    rd(2'd0, v); chk("R6 flag cleared", v, 8'h80);

    // R9: restart clears counter
    wr(2'd1, 8'hA5, e);
    wr(2'd1, 8'h5A, e);
    wait_pulse(0, 4 * p, "R8 nmi must stay low", at);
    chk("R9 timeout after restart", at, e + p);

    // R10: bad sequences ignored
    wr(2'd1, 8'hA5, e);
    wr(2'd1, 8'h5A, e);
    wr(2'd1, 8'h5A, e2);
    wr(2'd1, 8'hA5, e2);
    wr(2'd1, 8'h00, e2);
    wr(2'd1, 8'h5A, e2);
    wait_pulse(0, 4 * p, "R8 nmi must stay low", at);
    chk("R10 bad sequences ignored", at, e + p);

    // R9 R10 R13: random restart traffic against a bench model
    wr(2'd1, 8'hA5, e);
    wr(2'd1, 8'h5A, e);
    mcnt = 0; armed = 0; exp_p = 0;
    for (int i = 0; i < 600; i++) begin
      chk("R9 R10 R13 random rst_req", rst_req, exp_p);
      case ($urandom % 8)
        0: begin w = 1; b = 8'hA5; end
        1: begin w = 1; b = 8'h5A; end
        2: begin w = 1; b = 8'($urandom); end
        default: begin w = 0; b = 8'h00; end
      endcase
      bus_sel = w; bus_wr = w; bus_addr = 2'd1; bus_wdata = b;
      if (w && armed && b == 8'h5A) begin
        mcnt = 0; exp_p = 0;
      end else begin
        exp_p = (mcnt == p - 1);
        mcnt = exp_p ? 0 : mcnt + 1;
      end
      if (w) armed = (b == 8'hA5);
      @(negedge clk);
    end
    bus_sel = 0; bus_wr = 0;

    // R12: make sure flag is set, then system reset keeps it
    wr(2'd0, 8'h40, e);
    wait_pulse(0, 4 * p, "R8 nmi must stay low", at);
    apply_reset(0);
    rd(2'd0, v); chk("R12 flag kept over system reset", v, 8'h40);

    // R8 R4: NMI action, period 01
    p = period(1);
    wr(2'd0, 8'h85, e);
    wait_pulse(1, 2 * p, "R8 rst_req must stay low", at);
    chk("R8 R4 nmi timeout edge", at, e + p);
    @(negedge clk);
    chk("R8 nmi pulse one cycle", nmi_req, 0);

    // R11: slow source, period 00
    apply_reset(0);
    p = period(0);
    tick_en = 1;
    wr(2'd0, 8'h88, e);
    e2 = ((e / 4) + 1) * 4 + 4 * (p - 1);
    wait_pulse(0, 8 * p, "R8 nmi must stay low", at);
    chk("R11 slow tick timeout edge", at, e2);
    tick_en = 0;

    // R12: power-on clears flag
    apply_reset(1);
    rd(2'd0, v); chk("R12 flag cleared by power-on", v, 8'h00);

    // R4: periods 10 and 11
    for (int s = 2; s < 4; s++) begin
      apply_reset(1);
      p = period(s);
      wr(2'd0, 8'(8'h80 | s), e);
      rd(2'd0, v); chk("R4 period field readback", v, 8'h80 | s);
      wait_pulse(0, 2 * p, "R8 nmi must stay low", at);
      chk("R4 long period timeout edge", at, e + p);
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule